// File: doc/BRIEF.md
# Multi-Format Audio Serial Transmitter

This block turns a stream of parallel left/right sample pairs into a serial audio bit stream. The output has one data line, a bit clock and a frame alignment clock. Four framings are selectable: left-justified, right-justified, I2S and a DSP-style framing with a short sync pulse. In every framing the most significant bit goes first, and slot positions that carry no sample bit are driven low. Each channel slot is `SLOT_W` bit periods long, so a frame is `2*SLOT_W` periods.

When `master` is high, the block makes its own bit clock by dividing the system clock, derives the alignment clock from its frame position, and drives both pins with `clk_oe` high. When `master` is low, the block takes the bit and alignment clocks from an external source that uses the same slot length. Both clocks pass through synchronizers into the system clock domain. Each external alignment transition resets the frame position, and every falling bit-clock edge moves the data forward by one bit. In either role the data line changes only after a falling bit-clock edge.

Samples arrive on a valid/ready port with a one-pair holding slot. `s_ready` is high exactly when the slot is empty. A pair is taken on a clock edge where `s_valid` and `s_ready` are both high. The pair stays in the slot until the frame reaches the start of the left word, and at that point it becomes the word being sent. While the slot is full, `s_ready` stays low. The source must then hold `s_valid` and its data until a transfer happens.

Top module: `aud_ser_tx`

## Requirements
- R1: While `rst_n` is low: `s_ready` is 1, and `sdata`, `bclk_out` and `lrclk_out` are 0.
- R2: With `master`=1, `clk_oe` is 1. `bclk_out` stays high for `HALF_DIV` system clocks and then low for `HALF_DIV` system clocks. `sdata` and `lrclk_out` change only in the cycle where `bclk_out` falls.
- R3: `wl_sel` sets the word length: 0 gives 16 bits, 1 gives 20, 2 gives 24 and 3 gives 32. The word is taken from bits [len-1:0] of `s_left`/`s_right` and sent MSB first. Bits above the word length have no effect on `sdata`.
- R4: `fmt`=0 (left-justified): `lrclk_out` is high during the left slot. The MSB is in the first bit period after the alignment edge, and the periods after the LSB are 0.
- R5: `fmt`=1 (right-justified): `lrclk_out` is high during the left slot. The LSB is in the last bit period of the slot, and the leading periods are 0.
- R6: `fmt`=2 (I2S): `lrclk_out` is low during the left slot. The MSB comes one bit period after the alignment edge. With a 32-bit word, the LSB lands in the first period after the next edge.
- R7: `fmt`=3 (DSP): `lrclk_out` is high for exactly one bit period, and that period comes just before the left MSB. The right word follows the left LSB at once, and the rest of the frame is 0.
- R8: `s_ready` goes low in the cycle after a transfer. It rises again in the cycle where the held pair becomes the current word, which is the bit period holding the start of the left word. Each pair is sent in the frame that starts at that point.
- R9: If no pair is waiting when a new frame's left word starts, that whole frame is sent as 0 data.
- R10: With `master`=0: `clk_oe`, `bclk_out` and `lrclk_out` are 0. `sdata` follows falling edges of `bclk_in`. The frame position realigns at each `lrclk_in` transition: a rise starts the left slot in formats 0 and 1, a fall starts it in format 2, and a rise marks the sync period in format 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| master | input | 1 | 1 = generate the clocks, 0 = follow the external clocks |
| fmt | input | 2 | Framing: 0 left-justified, 1 right-justified, 2 I2S, 3 DSP |
| wl_sel | input | 2 | Word length: 16/20/24/32 bits |
| s_valid | input | 1 | Sample pair valid |
| s_ready | output | 1 | Holding slot empty |
| s_left | input | SAMPLE_W | Left sample, right-aligned |
| s_right | input | SAMPLE_W | Right sample, right-aligned |
| bclk_in | input | 1 | External bit clock (slave role) |
| lrclk_in | input | 1 | External alignment clock (slave role) |
| bclk_out | output | 1 | Generated bit clock (master role) |
| lrclk_out | output | 1 | Generated alignment clock (master role) |
| clk_oe | output | 1 | Clock pin output enable |
| sdata | output | 1 | Serial data |

## Verification
The bench uses I2S with a full 32-bit word to check that the LSB of the right word wraps into the first period of the next frame. A design that mishandled that wrap would lose the bit or shift the whole frame. It uses 32-bit DSP words to check that the sync pulse and the right LSB share the last period, and it puts ones in the bits above the word length, which any masking error would leak onto the line. It pushes two pairs back to back and then stops pushing. A wrong holding slot would overwrite, repeat or drop a word instead of producing the word, the next word and then a silent frame. In slave mode the external clocks start at an arbitrary frame phase, so a block that did not realign on alignment edges would send its bits in the wrong slots.

// File: rtl/aud_tx_pkg.sv
package aud_tx_pkg;

  typedef enum logic [1:0] {
    FMT_LJ  = 2'd0,
    FMT_RJ  = 2'd1,
    FMT_I2S = 2'd2,
    FMT_DSP = 2'd3
  } fmt_e;

  // word length code to number of bits
  function automatic logic [5:0] wl_bits(input logic [1:0] code);
    case (code)
      2'd0:    return 6'd16;
      2'd1:    return 6'd20;
      2'd2:    return 6'd24;
      default: return 6'd32;
    endcase
  endfunction

endpackage

// File: rtl/aud_tx_bclk_gen.sv
module aud_tx_bclk_gen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic bclk,
  output logic fall_tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] TOP = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;
  logic          bclk_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt_q  <= '0;
      bclk_q <= 1'b0;
    end else if (cnt_q == TOP) begin
      cnt_q  <= '0;
      bclk_q <= ~bclk_q;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  // the cycle that ends a high phase: the edge at its end drops bclk
  assign fall_tick = run && (cnt_q == TOP) && bclk_q;
  assign bclk      = bclk_q;

endmodule

// File: rtl/aud_tx_slv_sync.sv
module aud_tx_slv_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_in,
  input  logic lrclk_in,
  output logic fall_tick,
  output logic lr_lvl
);
  logic [STAGES-1:0] b_sh, l_sh;
  logic              b_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      b_sh   <= '0;
      l_sh   <= '0;
      b_last <= 1'b0;
    end else begin
      b_sh   <= {b_sh[STAGES-2:0], bclk_in};
      l_sh   <= {l_sh[STAGES-2:0], lrclk_in};
      b_last <= b_sh[STAGES-1];
    end
  end

  // both chains have equal depth, so lr_lvl lines up with the detected edge
  assign fall_tick = b_last & ~b_sh[STAGES-1];
  assign lr_lvl    = l_sh[STAGES-1];

endmodule

// File: rtl/aud_tx_framer.sv
module aud_tx_framer
  import aud_tx_pkg::*;
#(
  parameter int SLOT_W = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        master,
  input  fmt_e                        fmt,
  input  logic                        adv,
  input  logic                        lr_s,
  output logic [$clog2(2*SLOT_W)-1:0] ep,
  output logic                        lr_q
);
  localparam int FRAME = 2 * SLOT_W;
  localparam int FW    = $clog2(FRAME);
  localparam logic [FW-1:0] LAST = FW'(FRAME - 1);
  localparam logic [FW-1:0] HALF = FW'(SLOT_W);

  logic [FW-1:0] pos_q, pos_nxt, wrap_pos;
  logic          lr_seen, lr_nxt;

  assign wrap_pos = (pos_q == LAST) ? '0 : pos_q + FW'(1);

  // next frame position; in slave role an alignment edge overrides the count
  always_comb begin
    pos_nxt = wrap_pos;
    if (!master && (lr_s != lr_seen)) begin
      case (fmt)
        FMT_LJ, FMT_RJ: pos_nxt = lr_s ? '0 : HALF;
        FMT_I2S:        pos_nxt = lr_s ? HALF : '0;
        default:        if (lr_s) pos_nxt = LAST;
      endcase
    end
  end

  // effective position: I2S data lags its alignment clock by one bit
  assign ep = (fmt == FMT_I2S) ? ((pos_nxt == '0) ? LAST : pos_nxt - FW'(1))
                               : pos_nxt;

  always_comb begin
    case (fmt)
      FMT_LJ, FMT_RJ: lr_nxt = (pos_nxt < HALF);
      FMT_I2S:        lr_nxt = (pos_nxt >= HALF);
      default:        lr_nxt = (pos_nxt == LAST);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q   <= LAST;
      lr_seen <= 1'b0;
      lr_q    <= 1'b0;
    end else if (adv) begin
      pos_q   <= pos_nxt;
      lr_seen <= lr_s;
      lr_q    <= lr_nxt;
    end
  end

endmodule

// File: rtl/aud_tx_shifter.sv
module aud_tx_shifter
  import aud_tx_pkg::*;
#(
  parameter int SLOT_W   = 32,
  parameter int SAMPLE_W = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        s_valid,
  output logic                        s_ready,
  input  logic [SAMPLE_W-1:0]         s_left,
  input  logic [SAMPLE_W-1:0]         s_right,
  input  logic [1:0]                  wl_sel,
  input  fmt_e                        fmt,
  input  logic                        adv,
  input  logic [$clog2(2*SLOT_W)-1:0] ep,
  output logic                        sdata
);
  localparam int SIW = $clog2(SAMPLE_W);

  logic [SAMPLE_W-1:0] pend_l, pend_r, cur_l, cur_r, src_l, src_r, word;
  logic                pend_v, load, accept, bit_nxt, sdata_q;

  assign s_ready = ~pend_v;
  assign accept  = s_valid & ~pend_v;
  assign load    = adv && (ep == '0);

  // word in force for the bit being produced (a fresh load counts at once)
  assign src_l = load ? (pend_v ? pend_l : '0) : cur_l;
  assign src_r = load ? (pend_v ? pend_r : '0) : cur_r;

  always_comb begin
    int e, w, i, k;
    logic use_r, hit;
    e     = int'(ep);
    w     = int'(wl_bits(wl_sel));
    i     = (e >= SLOT_W) ? e - SLOT_W : e;
    use_r = (e >= SLOT_W);
    hit   = 1'b0;
    k     = 0;
    case (fmt)
      FMT_DSP: begin
        use_r = 1'b0;
        if (e < w) begin
          hit = 1'b1;
          k   = w - 1 - e;
        end else if (e < 2 * w) begin
          hit   = 1'b1;
          use_r = 1'b1;
          k     = 2 * w - 1 - e;
        end
      end
      FMT_RJ: begin
        if (i >= SLOT_W - w) begin
          hit = 1'b1;
          k   = SLOT_W - 1 - i;
        end
      end
      default: begin
        if (i < w) begin
          hit = 1'b1;
          k   = w - 1 - i;
        end
      end
    endcase
    word    = use_r ? src_r : src_l;
    bit_nxt = hit & word[SIW'(k)];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_v  <= 1'b0;
      pend_l  <= '0;
      pend_r  <= '0;
      cur_l   <= '0;
      cur_r   <= '0;
      sdata_q <= 1'b0;
    end else begin
      pend_v <= accept ? 1'b1 : (load ? 1'b0 : pend_v);
      if (accept) begin
        pend_l <= s_left;
        pend_r <= s_right;
      end
      if (load) begin
        cur_l <= src_l;
        cur_r <= src_r;
      end
      if (adv) sdata_q <= bit_nxt;
    end
  end

  assign sdata = sdata_q;

endmodule

// File: rtl/aud_ser_tx.sv
module aud_ser_tx
  import aud_tx_pkg::*;
#(
  parameter int SLOT_W      = 32,
  parameter int SAMPLE_W    = 32,
  parameter int HALF_DIV    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                master,
  input  logic [1:0]          fmt,
  input  logic [1:0]          wl_sel,
  input  logic                s_valid,
  output logic                s_ready,
  input  logic [SAMPLE_W-1:0] s_left,
  input  logic [SAMPLE_W-1:0] s_right,
  input  logic                bclk_in,
  input  logic                lrclk_in,
  output logic                bclk_out,
  output logic                lrclk_out,
  output logic                clk_oe,
  output logic                sdata
);
  localparam int FW = $clog2(2 * SLOT_W);

  fmt_e          fmt_c;
  logic          tick_m, tick_s, lr_s, adv, bclk_q, lr_q;
  logic [FW-1:0] ep;

  assign fmt_c = fmt_e'(fmt);

  aud_tx_bclk_gen #(.HALF_DIV(HALF_DIV)) u_bclk (
    .clk(clk), .rst_n(rst_n), .run(master), .bclk(bclk_q), .fall_tick(tick_m)
  );

  aud_tx_slv_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .bclk_in(bclk_in), .lrclk_in(lrclk_in),
    .fall_tick(tick_s), .lr_lvl(lr_s)
  );

  assign adv = master ? tick_m : tick_s;

  aud_tx_framer #(.SLOT_W(SLOT_W)) u_frm (
    .clk(clk), .rst_n(rst_n), .master(master), .fmt(fmt_c), .adv(adv),
    .lr_s(lr_s), .ep(ep), .lr_q(lr_q)
  );

  aud_tx_shifter #(.SLOT_W(SLOT_W), .SAMPLE_W(SAMPLE_W)) u_shf (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_left(s_left), .s_right(s_right), .wl_sel(wl_sel), .fmt(fmt_c),
    .adv(adv), .ep(ep), .sdata(sdata)
  );

  assign bclk_out  = master & bclk_q;
  assign lrclk_out = master & lr_q;
  assign clk_oe    = master;

endmodule

// File: rtl/aud_ser_tx_chk.sv
module aud_ser_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       master,
  input logic [1:0] fmt,
  input logic       s_valid,
  input logic       s_ready,
  input logic       bclk_out,
  input logic       lrclk_out,
  input logic       sdata
);

  a_r2_data_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (master && $past(master) && (sdata != $past(sdata)))
      |-> ($past(bclk_out) && !bclk_out));

  a_r2_lr_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (master && $past(master) && (lrclk_out != $past(lrclk_out)))
      |-> ($past(bclk_out) && !bclk_out));

  a_r7_sync_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (master && $past(master) && fmt == 2'd3 && $past(fmt) == 2'd3 &&
     lrclk_out && $past(lrclk_out))
      |-> !($past(bclk_out) && !bclk_out));

  a_r8_full_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> !s_ready);

endmodule

bind aud_ser_tx aud_ser_tx_chk u_chk (.*);

// File: tb/aud_ser_tx_test.sv
module aud_ser_tx_test;
  localparam int S = 32, F = 64, HD = 2;

  logic clk = 1'b0, rst_n = 1'b0, master = 1'b1;
  logic [1:0] fmt = 2'd0, wl_sel = 2'd2;
  logic s_valid = 1'b0;
  logic [31:0] s_left = '0, s_right = '0;
  logic bclk_in = 1'b0, lrclk_in = 1'b0;
  logic s_ready, bclk_out, lrclk_out, clk_oe, sdata;
  logic bref;
  int n_chk = 0, n_bad = 0;
  bit slv_run = 0, done = 0;

  aud_ser_tx uut (
    .clk(clk), .rst_n(rst_n), .master(master), .fmt(fmt), .wl_sel(wl_sel),
    .s_valid(s_valid), .s_ready(s_ready), .s_left(s_left), .s_right(s_right),
    .bclk_in(bclk_in), .lrclk_in(lrclk_in), .bclk_out(bclk_out),
    .lrclk_out(lrclk_out), .clk_oe(clk_oe), .sdata(sdata)
  );

  always #4 clk = ~clk;
  assign bref = master ? bclk_out : bclk_in;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int wlen(input logic [1:0] c);
    case (c)
      2'd0: return 16;
      2'd1: return 20;
      2'd2: return 24;
      default: return 32;
    endcase
  endfunction

  // expected data per effective bit period, index 0 = left MSB slot start
  function automatic logic [F-1:0] exp_data(input logic [1:0] f, input int w,
                                            input logic [31:0] l, input logic [31:0] r);
    logic [F-1:0] v = '0;
    for (int b = 0; b < w; b++) begin
      case (f)
        2'd1: begin v[S-w+b] = l[w-1-b]; v[2*S-w+b] = r[w-1-b]; end
        2'd3: begin v[b] = l[w-1-b]; v[w+b] = r[w-1-b]; end
        default: begin v[b] = l[w-1-b]; v[S+b] = r[w-1-b]; end
      endcase
    end
    return v;
  endfunction

  function automatic logic [F-1:0] exp_lr(input logic [1:0] f);
    logic [F-1:0] v = '0;
    for (int e = 0; e < F; e++) begin
      case (f)
        2'd2: v[e] = (((e + 1) % F) >= S);
        2'd3: v[e] = (e == F - 1);
        default: v[e] = (e < S);
      endcase
    end
    return v;
  endfunction

  function automatic logic slv_lr(input int p);
    case (fmt)
      2'd2: return p >= S;
      2'd3: return p == F - 1;
      default: return p < S;
    endcase
  endfunction

  // external clock source for the slave role, starting mid-frame
  initial begin
    int sp;
    wait (slv_run);
    @(negedge clk);
    sp = 37;
    forever begin
      repeat (8) @(negedge clk);
      bclk_in = 1'b1;
      repeat (8) @(negedge clk);
      bclk_in = 1'b0;
      sp = (sp + 1) % F;
      lrclk_in = slv_lr(sp);
    end
  end

  task automatic push(input logic [31:0] l, input logic [31:0] r);
    @(negedge clk);
    s_left = l; s_right = r; s_valid = 1'b1;
    while (!s_ready) @(negedge clk);
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic wait_load();
    while (!s_ready) @(negedge clk);
  endtask

  task automatic collect(input int n, output logic [2*F-1:0] d, output logic [2*F-1:0] lr);
    d = '0; lr = '0;
    for (int i = 0; i < n; i++) begin
      @(posedge bref); #1;
      d[i] = sdata; lr[i] = lrclk_out;
    end
  endtask

  task automatic run_frame(input logic [1:0] f, input logic [1:0] wc,
                           input logic [31:0] l, input logic [31:0] r, input string tag);
    logic [2*F-1:0] d, lr;
    logic [F-1:0] ed;
    @(negedge clk); fmt = f; wl_sel = wc;
    push(l, r);
    wait_load();
    collect(F, d, lr);
    ed = exp_data(f, wlen(wc), l, r);
    check(d[F-1:0] == ed, tag, "frame data", d[F-1:0], ed);
    if (master) check(lr[F-1:0] == exp_lr(f), tag, "alignment clock", lr[F-1:0], exp_lr(f));
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check(s_ready == 1'b1, "R1", "s_ready in reset", 64'(s_ready), 64'd1);
    check(sdata == 1'b0, "R1", "sdata in reset", 64'(sdata), 64'd0);
    check(bclk_out == 1'b0, "R1", "bclk_out in reset", 64'(bclk_out), 64'd0);
    check(lrclk_out == 1'b0, "R1", "lrclk_out in reset", 64'(lrclk_out), 64'd0);
  endtask

  task automatic t_bclk_period();
    int hi = 0, lo = 0;
    @(negedge clk);
    while (bclk_out) @(negedge clk);
    while (!bclk_out) @(negedge clk);
    while (bclk_out) begin hi++; @(negedge clk); end
    while (!bclk_out) begin lo++; @(negedge clk); end
    check(hi == HD, "R2", "bclk high cycles", 64'(hi), 64'(HD));
    check(lo == HD, "R2", "bclk low cycles", 64'(lo), 64'(HD));
    check(clk_oe == 1'b1, "R2", "clk_oe master", 64'(clk_oe), 64'd1);
  endtask

  task automatic t_backpressure();
    logic [2*F-1:0] d, lr;
    logic [F-1:0] ea, eb;
    @(negedge clk); fmt = 2'd0; wl_sel = 2'd3;
    push(32'h8765_4321, 32'h0F0F_1234);
    check(s_ready == 1'b0, "R8", "s_ready after transfer", 64'(s_ready), 64'd0);
    push(32'hDEAD_BEEF, 32'hC001_D00D);
    collect(2 * F, d, lr);
    ea = exp_data(2'd0, 32, 32'h8765_4321, 32'h0F0F_1234);
    eb = exp_data(2'd0, 32, 32'hDEAD_BEEF, 32'hC001_D00D);
    check(d[F-1:0] == ea, "R8", "first held pair", d[F-1:0], ea);
    check(d[2*F-1:F] == eb, "R8", "second pair next frame", d[2*F-1:F], eb);
  endtask

  task automatic t_underrun();
    logic [2*F-1:0] d, lr;
    logic [F-1:0] ea;
    @(negedge clk); fmt = 2'd0; wl_sel = 2'd2;
    push(32'h00A5_C3F1, 32'h005A_3C1F);
    wait_load();
    collect(2 * F, d, lr);
    ea = exp_data(2'd0, 24, 32'h00A5_C3F1, 32'h005A_3C1F);
    check(d[F-1:0] == ea, "R9", "frame before underrun", d[F-1:0], ea);
    check(d[2*F-1:F] == '0, "R9", "silent frame", d[2*F-1:F], 64'd0);
  endtask

  task automatic t_slave();
    @(negedge clk); master = 1'b0; fmt = 2'd0; slv_run = 1;
    repeat (1200) @(negedge clk);
    check(clk_oe == 1'b0, "R10", "clk_oe slave", 64'(clk_oe), 64'd0);
    check(bclk_out == 1'b0 && lrclk_out == 1'b0, "R10", "clock outputs idle",
          {62'd0, bclk_out, lrclk_out}, 64'd0);
    run_frame(2'd0, 2'd2, 32'h0012_3456, 32'h00FE_DCBA, "R10 R4 slave");
    @(negedge clk); fmt = 2'd2;
    repeat (1200) @(negedge clk);
    run_frame(2'd2, 2'd0, 32'h0000_B00C, 32'h0000_7A31, "R10 R6 slave");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog (all requirements): actual hang expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_bclk_period();
    run_frame(2'd0, 2'd2, 32'hFF9A_B1C3, 32'hFF35_7E0D, "R4 R3");
    run_frame(2'd0, 2'd0, 32'hFFFF_8001, 32'hA5A5_4C3D, "R3");
    run_frame(2'd1, 2'd1, 32'hFFF9_0F3C, 32'h0008_1234, "R5 R3");
    run_frame(2'd1, 2'd3, 32'hC3A5_9601, 32'h7E81_24F0, "R5");
    run_frame(2'd2, 2'd2, 32'h0080_0001, 32'h00C0_FFEE, "R6");
    run_frame(2'd2, 2'd3, 32'h9234_5671, 32'hF00D_CAF3, "R6");
    run_frame(2'd3, 2'd0, 32'hFFFF_B00B, 32'h0000_E5E7, "R7");
    run_frame(2'd3, 2'd3, 32'h8000_0003, 32'hC000_0005, "R7");
    t_backpressure();
    t_underrun();
    t_slave();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule